// File: doc/BRIEF.md
# Four-Channel PWM Timer Bank with Error Detection

The block holds four independent pulse-width timers behind one small register port. Each timer counts from 1 up to its programmed period, then starts again at 1. Its output pin stays high while the count is at or below the programmed width and low for the rest of the period. Software starts and stops timers through two enable registers: one sets enable bits and the other clears them.

Every timer checks itself for three faults. The first is a period that is too short on the first running cycle. The second is a width that is not below the period when the counter rolls over. The third is a counter that reaches its all-ones value without matching the period. A shared status word collects, for each timer, a rollover interrupt latch, an error latch and a two-bit error code. Software clears the latches by writing ones to them.

One interrupt line merges the latched events of all timers. Several timers can therefore be served by a single handler, which clears all latches with one write.

Top module: `pwmt_bank`

## Requirements
- R1: Writing a mask to address 0 sets those timer enable bits, and writing a mask to address 1 clears them. A read of either address returns the enable mask in bits NT-1:0. A timer that is already running is not restarted.
- R2: A running timer with period P counts 1, 2, ... P. On the cycle where the count equals P, the count is reloaded with 1, so the output repeats every P cycles.
- R3: The output `pwm_out[i]` is high while timer i runs and its count is at or below its width. It is low otherwise, and always low while the timer is disabled.
- R4: Timer i's interrupt latch (status bit i) sets at each rollover when bit 0 of its configuration register (address 8+4i) is 1. It never sets when that bit is 0.
- R5: On the first running cycle after enable, a period below 2 latches timer i's error bit (status bit 16+i) and error code 2'b10 (status bits 9+2i:8+2i).
- R6: At rollover, a width greater than or equal to the period latches the error bit with code 2'b11. If more than one error occurs in the same cycle, code 10 takes priority over 11, and 11 over 01.
- R7: When the count reaches its all-ones value without matching the period, the error bit latches with code 2'b01 and the count is reloaded with 1.
- R8: An error is latched whether or not the timer's interrupt enable is set. It drives `irq` only while that enable is 1.
- R9: Writing ones to status address 2 clears the selected interrupt latches (bits 3:0) and error latches (bits 19:16). Writing 0x000F000F clears them all in one access. Clearing an error latch also returns its code to 00.
- R10: `irq` is the OR of all interrupt latches and of the error latches whose timer has its interrupt enable set. It drops in the cycle after the write that clears the last contributing latch.
- R11: When a latch is set and cleared in the same cycle, it stays set.
- R12: Timers enabled by the same write with equal periods set their interrupt latches in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | NT | Per-timer PWM output |
| irq | output | 1 | Combined interrupt request |

## Verification
The first running cycle of a timer is the cycle right after the enable write's clock edge, and in that cycle the count is 1. Events detected in a cycle appear in the status word, and on `irq`, one clock edge later. Outputs and read data are sampled only at the falling edge, so a rollover in cycle N is looked for at the falling edge of cycle N+1. The set-wins case is read back one falling edge after the colliding clear. The drop of `irq` is checked at the first falling edge after the clearing write.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    ET_NONE  = 2'b00,
    ET_OVF   = 2'b01,
    ET_SHORT = 2'b10,
    ET_WIDE  = 2'b11
  } etype_e;

  localparam int A_EN_SET   = 0;
  localparam int A_EN_CLR   = 1;
  localparam int A_STATUS   = 2;
  localparam int A_TMR_BASE = 8;

  localparam int F_CFG    = 0;
  localparam int F_PERIOD = 1;
  localparam int F_WIDTH  = 2;

  localparam int STS_INT_LSB   = 0;
  localparam int STS_ETYPE_LSB = 8;
  localparam int STS_ERR_LSB   = 16;

endpackage

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pwm_o,
  output logic             roll_o,
  output logic             err_o,
  output logic [1:0]       etype_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_P   = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             cnt_en;
  logic             roll, ovf, short_ev, wide_ev;
  etype_e           etype;

  always_comb begin
    roll     = run_i && (cnt_q == period_i);
    ovf      = run_i && (cnt_q == CNT_MAX) && !roll;
    short_ev = run_i && first_q && (period_i < MIN_P);
    wide_ev  = roll && (width_i >= period_i);
    if (short_ev)     etype = ET_SHORT;
    else if (wide_ev) etype = ET_WIDE;
    else if (ovf)     etype = ET_OVF;
    else              etype = ET_NONE;
  end

  always_comb begin
    cnt_en  = start_i || run_i;
    first_d = start_i;
    if (start_i || roll || ovf) cnt_d = CNT_ONE;
    else                        cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= first_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pwm_o   = run_i && (cnt_q <= width_i);
  assign roll_o  = roll;
  assign err_o   = short_ev || wide_ev || ovf;
  assign etype_o = etype;

  AST_RELOAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll && !start_i) |=> (cnt_q == CNT_ONE)); // R2
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !start_i) |=> (cnt_q == CNT_ONE)); // R7
  AST_STARTUP_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q && run_i && (period_i < MIN_P)) |-> (err_o && etype_o == ET_SHORT)); // R5
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o); // R3

endmodule

// File: rtl/pwmt_status.sv
module pwmt_status #(
  parameter int NT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NT-1:0]       roll_i,
  input  logic [NT-1:0]       ien_i,
  input  logic [NT-1:0]       err_i,
  input  logic [NT-1:0][1:0]  etype_i,
  input  logic [NT-1:0]       clr_int_i,
  input  logic [NT-1:0]       clr_err_i,
  output logic [NT-1:0]       int_o,
  output logic [NT-1:0]       err_o,
  output logic [NT-1:0][1:0]  etype_o,
  output logic                irq_o
);

  logic [NT-1:0]      int_q, int_d, err_q, err_d, set_int;
  logic [NT-1:0][1:0] ety_q, ety_d;

  always_comb begin
    set_int = roll_i & ien_i;
    int_d   = set_int | (int_q & ~clr_int_i);
    err_d   = err_i | (err_q & ~clr_err_i);
    for (int i = 0; i < NT; i++) begin
      if (err_i[i])          ety_d[i] = etype_i[i];
      else if (clr_err_i[i]) ety_d[i] = 2'b00;
      else                   ety_d[i] = ety_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= '0;
      err_q <= '0;
      ety_q <= '0;
    end else begin
      int_q <= int_d;
      err_q <= err_d;
      ety_q <= ety_d;
    end
  end

  assign int_o   = int_q;
  assign err_o   = err_q;
  assign etype_o = ety_q;
  assign irq_o   = |(int_q | (err_q & ien_i));

  for (genvar g = 0; g < NT; g++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_int[g] |=> int_q[g]); // R11
    AST_CODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !err_q[g] |-> (ety_q[g] == 2'b00)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_q[g] && !clr_err_i[g]) |=> err_q[g]); // R8
  end

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int NT     = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  input  logic                   we_i,
  input  logic [NT-1:0]          int_i,
  input  logic [NT-1:0]          err_i,
  input  logic [NT-1:0][1:0]     etype_i,
  output logic [31:0]            rdata_o,
  output logic [NT-1:0]          en_o,
  output logic [NT-1:0]          start_o,
  output logic [NT-1:0]          ien_o,
  output logic [NT-1:0][CNT_W-1:0] period_o,
  output logic [NT-1:0][CNT_W-1:0] width_o,
  output logic [NT-1:0]          clr_int_o,
  output logic [NT-1:0]          clr_err_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = (NT > 1) ? $clog2(NT) : 1;

  logic [NT-1:0]            en_q, en_d, set_m, clr_m;
  logic [NT-1:0]            ien_q;
  logic [NT-1:0][CNT_W-1:0] per_q, wid_q;
  logic [ADDR_W-1:0]        toff;
  logic [IDX_W-1:0]         tidx;
  logic [1:0]               tfld;
  logic [SEL_W-1:0]         tsel;
  logic                     in_tmr;
  logic [31:0]              sts;
  logic                     unused_bits;

  always_comb begin
    toff   = addr_i - ADDR_W'(A_TMR_BASE);
    tidx   = toff[ADDR_W-1:2];
    tfld   = toff[1:0];
    tsel   = SEL_W'(tidx);
    in_tmr = (addr_i >= ADDR_W'(A_TMR_BASE)) && (int'(tidx) < NT);
  end

  always_comb begin
    set_m     = (we_i && addr_i == ADDR_W'(A_EN_SET)) ? wdata_i[NT-1:0] : '0;
    clr_m     = (we_i && addr_i == ADDR_W'(A_EN_CLR)) ? wdata_i[NT-1:0] : '0;
    en_d      = (en_q | set_m) & ~clr_m;
    start_o   = set_m & ~en_q;
    clr_int_o = (we_i && addr_i == ADDR_W'(A_STATUS)) ? wdata_i[STS_INT_LSB +: NT] : '0;
    clr_err_o = (we_i && addr_i == ADDR_W'(A_STATUS)) ? wdata_i[STS_ERR_LSB +: NT] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic wr_cfg, wr_per, wr_wid;
    assign wr_cfg = we_i && in_tmr && (int'(tidx) == g) && (tfld == 2'(F_CFG));
    assign wr_per = we_i && in_tmr && (int'(tidx) == g) && (tfld == 2'(F_PERIOD));
    assign wr_wid = we_i && in_tmr && (int'(tidx) == g) && (tfld == 2'(F_WIDTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ien_q[g] <= 1'b0;
        per_q[g] <= '0;
        wid_q[g] <= '0;
      end else begin
        if (wr_cfg) ien_q[g] <= wdata_i[0];
        if (wr_per) per_q[g] <= wdata_i[CNT_W-1:0];
        if (wr_wid) wid_q[g] <= wdata_i[CNT_W-1:0];
      end
    end

    AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[g] |=> en_q[g]); // R1
  end

  always_comb begin
    sts = '0;
    for (int i = 0; i < NT; i++) begin
      sts[STS_INT_LSB + i]           = int_i[i];
      sts[STS_ERR_LSB + i]           = err_i[i];
      sts[STS_ETYPE_LSB + 2*i +: 2]  = etype_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_EN_SET) || addr_i == ADDR_W'(A_EN_CLR)) begin
      rdata_o = 32'(en_q);
    end else if (addr_i == ADDR_W'(A_STATUS)) begin
      rdata_o = sts;
    end else if (in_tmr) begin
      case (tfld)
        2'(F_CFG):    rdata_o = 32'(ien_q[tsel]);
        2'(F_PERIOD): rdata_o = 32'(per_q[tsel]);
        2'(F_WIDTH):  rdata_o = 32'(wid_q[tsel]);
        default:      rdata_o = '0;
      endcase
    end
  end

  assign unused_bits = ^{wdata_i, tidx};
  assign en_o     = en_q;
  assign ien_o    = ien_q;
  assign period_o = per_q;
  assign width_o  = wid_q;

endmodule

// File: rtl/pwmt_bank.sv
module pwmt_bank
  import pwmt_pkg::*;
#(
  parameter int NT         = 4,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 6,
  parameter int MIN_PERIOD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  output logic [NT-1:0]     pwm_out,
  output logic              irq
);

  logic [1:0]               rst_sync_q;
  logic                     rst_ni;
  logic [NT-1:0]            en, start, ien, roll, err_ev, int_l, err_l, clr_int, clr_err;
  logic [NT-1:0][1:0]       ety_ev, ety_l;
  logic [NT-1:0][CNT_W-1:0] period, width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pwmt_regs #(.NT(NT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .int_i     (int_l),
    .err_i     (err_l),
    .etype_i   (ety_l),
    .rdata_o   (rdata),
    .en_o      (en),
    .start_o   (start),
    .ien_o     (ien),
    .period_o  (period),
    .width_o   (width),
    .clr_int_o (clr_int),
    .clr_err_o (clr_err)
  );

  for (genvar g = 0; g < NT; g++) begin : g_ch
    pwmt_channel #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_ch (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .start_i  (start[g]),
      .run_i    (en[g]),
      .period_i (period[g]),
      .width_i  (width[g]),
      .pwm_o    (pwm_out[g]),
      .roll_o   (roll[g]),
      .err_o    (err_ev[g]),
      .etype_o  (ety_ev[g])
    );
  end

  pwmt_status #(.NT(NT)) u_sts (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .roll_i    (roll),
    .ien_i     (ien),
    .err_i     (err_ev),
    .etype_i   (ety_ev),
    .clr_int_i (clr_int),
    .clr_err_i (clr_err),
    .int_o     (int_l),
    .err_o     (err_l),
    .etype_o   (ety_l),
    .irq_o     (irq)
  );

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(irq) |-> $past(we)); // R10

endmodule

// File: tb/pwmt_bank_test.sv
`timescale 1ns/1ps
module pwmt_bank_test;

  localparam int NT = 4;
  localparam int CW = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          we;
  logic [31:0]   rdata;
  logic [NT-1:0] pwm_out;
  logic          irq;

  int n_run  = 0;
  int n_fail = 0;

  // Vector table for timer 0: period, width, high cycles per period, error code
  localparam int NV = 6;
  localparam int VP[NV] = '{5, 8, 3, 6, 4, 1};
  localparam int VW[NV] = '{2, 4, 1, 6, 7, 0};
  localparam int VH[NV] = '{2, 4, 1, 6, 4, 0};
  localparam int VE[NV] = '{0, 0, 0, 3, 3, 2};

  pwmt_bank #(.NT(NT), .CNT_W(CW), .ADDR_W(AW), .MIN_PERIOD(2)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(a);
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi;
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state
    rd(0, v);  check("R1 reset enables", v, 32'h0);
    rd(2, v);  check("R9 reset status", v, 32'h0);
    check("R10 reset irq", 32'(irq), 32'h0);
    check("R3 reset pwm", 32'(pwm_out), 32'h0);

    // R1 enable set/clear; periods still 0 so timers 0 and 2 flag R5
    wr(0, 32'h5);
    rd(0, v);  check("R1 set mask", v, 32'h5);
    wr(1, 32'h1);
    rd(1, v);  check("R1 clear one", v, 32'h4);
    wr(1, 32'h4);
    rd(0, v);  check("R1 clear all", v, 32'h0);
    rd(2, v);  check("R5 startup short period", v, 32'h0005_2200);
    check("R8 error without enable keeps irq low", 32'(irq), 32'h0);
    wr(2, 32'h000F_000F);
    rd(2, v);  check("R9 bulk clear", v, 32'h0);

    // vector loop on timer 0 (R2, R3, R6)
    for (int i = 0; i < NV; i++) begin
      wr(8, 32'h1);
      wr(9, 32'(VP[i]));
      wr(10, 32'(VW[i]));
      wr(2, 32'h000F_000F);
      wr(0, 32'h1);
      hi = 0;
      for (int k = 0; k < 3*VP[i]; k++) begin
        @(negedge clk);
        if (pwm_out[0]) hi++;
      end
      check($sformatf("R2 R3 high cycles vec %0d", i), 32'(hi), 32'(3*VH[i]));
      wr(1, 32'h1);
      rd(2, v);
      check($sformatf("R6 code vec %0d", i), 32'(v[9:8]), 32'(VE[i]));
      check($sformatf("R4 int latch vec %0d", i), 32'(v[0]), 32'h1);
      check($sformatf("R3 idle low vec %0d", i), 32'(pwm_out[0]), 32'h0);
    end
    wr(2, 32'h000F_000F);

    // R4 / R10 timing: period 4, interrupt enabled
    wr(9, 32'd4); wr(10, 32'd2);
    wr(0, 32'h1);
    idle(4);
    check("R4 no latch before rollover", 32'(irq), 32'h0);
    idle(1);
    check("R4 latch after rollover", 32'(irq), 32'h1);
    wr(1, 32'h1);
    wr(2, 32'h1);
    @(negedge clk);
    check("R10 irq drops after clear", 32'(irq), 32'h0);

    // R8: error latched with interrupt enable off
    wr(8, 32'h0); wr(9, 32'd4); wr(10, 32'd9);
    wr(0, 32'h1);
    idle(8);
    wr(1, 32'h1);
    rd(2, v);  check("R8 err latched, no int", v, 32'h0001_0300);
    check("R8 irq masked", 32'(irq), 32'h0);
    wr(8, 32'h1);
    @(negedge clk);
    check("R8 irq follows enable", 32'(irq), 32'h1);
    wr(2, 32'h000F_000F);
    rd(2, v);  check("R9 clear resets code", v, 32'h0);
    check("R10 irq low after clear", 32'(irq), 32'h0);

    // R12: two timers, same period, one enable write
    wr(9, 32'd6); wr(10, 32'd3);
    wr(12, 32'h1); wr(13, 32'd6); wr(14, 32'd3);
    wr(0, 32'h3);
    for (int k = 0; k < 20 && !irq; k++) @(negedge clk);
    addr = AW'(2);
    #1 check("R12 same-cycle latches", 32'(rdata[1:0]), 32'h3);
    wr(1, 32'h3);
    wr(2, 32'h000F_000F);

    // R11: period 1 rolls every cycle; clear collides with set
    wr(9, 32'd1); wr(10, 32'd0);
    wr(0, 32'h1);
    idle(3);
    wr(2, 32'h1);
    rd(2, v);  check("R11 set wins", 32'(v[0]), 32'h1);
    wr(1, 32'h1);
    wr(2, 32'h000F_000F);
    rd(2, v);  check("R9 clear without set", v, 32'h0);

    // R7: timer 2 with period 0 runs into overflow
    wr(16, 32'h1); wr(17, 32'd0); wr(18, 32'd0);
    wr(0, 32'h4);
    idle(1100);
    wr(1, 32'h4);
    rd(2, v);  check("R7 overflow code", v, 32'h0004_1000);
    wr(2, 32'h000F_000F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule